// File: doc/BRIEF.md
# Asymmetric Conversion-Clock Prescaler with Half-Cycle Stretch

This block divides a system clock down to a conversion clock whose high and low phases are programmed separately. A 5-bit high field and a 3-bit low field each give a phase length in whole system cycles. A single adjust bit moves half a system cycle out of the low phase and into the high phase. This allows fine tuning of duty cycle and of the point where the clock edges fall, and the period does not change.

A divided edge can fall on a half-system-cycle boundary, so the block is clocked at twice the system rate and counts in half-cycle ticks. The phase lengths are taken from the fields at the start of each high phase. A change made part-way through a period therefore takes effect cleanly at the next rising edge. A one-tick strobe marks every rising edge of the divided clock for downstream logic.

Top module: `conv_clk_prescaler`

## Requirements
- R1: While rst_n is low, or while en is low at a clock edge, div_clk and rise_stb are 0 from that edge on.
- R2: When en is first sampled high, div_clk goes to 1 at that same edge, so the first high phase begins on the tick after release.
- R3: With half_adj = 0, the high phase lasts 2*(hi_cnt+1) ticks of clk2x.
- R4: With half_adj = 0, the low phase lasts 2*(lo_cnt+1) ticks of clk2x.
- R5: With half_adj = 1, the high phase lasts 2*(hi_cnt+1)+1 ticks and the low phase lasts 2*(lo_cnt+1)-1 ticks.
- R6: One full period (high plus low) lasts 2*(hi_cnt+lo_cnt+2) ticks whatever the value of half_adj.
- R7: hi_cnt, lo_cnt and half_adj are sampled only at the start of a high phase. A change during a period alters neither the current high phase nor the low phase that follows it.
- R8: rise_stb is 1 for exactly the first tick of every high phase and is 0 on every other tick.
- R9: Dropping en during a run forces div_clk low at the next edge. On re-enable, a fresh high phase starts at once, as R2 describes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the system rate; one period is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; when low, the divider is held idle |
| hi_cnt | input | HI_W (5) | High-phase field; the high phase is (hi_cnt+1) system cycles |
| lo_cnt | input | LO_W (3) | Low-phase field; the low phase is (lo_cnt+1) system cycles |
| half_adj | input | 1 | Moves half a system cycle from the low phase to the high phase |
| div_clk | output | 1 | Divided conversion clock |
| rise_stb | output | 1 | One-tick pulse on each rising edge of div_clk |

## Verification
The assertions assume that en and the fields are synchronous to clk2x. They also assume that reset is released while the counter is idle. Under these conditions a phase can end only when its tick count runs out, and the latched fields can move only on a high-phase start. The bench changes en and the fields only on the falling edge of clk2x. It changes the fields mid-period only in the test that targets the sampling point, so every other measured phase uses one stable setting.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  // Ticks (half system cycles) spent in the high phase.
  function automatic int unsigned high_ticks(int unsigned field, bit adj);
    return 2 * (field + 1) + (adj ? 1 : 0);
  endfunction

  // Ticks spent in the low phase; never below one because field >= 0.
  function automatic int unsigned low_ticks(int unsigned field, bit adj);
    return 2 * (field + 1) - (adj ? 1 : 0);
  endfunction

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

endpackage

// File: rtl/cdiv_field_latch.sv
module cdiv_field_latch #(
  parameter int HI_W = 5,
  parameter int LO_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_evt,
  input  logic [HI_W-1:0] hi_in,
  input  logic [LO_W-1:0] lo_in,
  input  logic            adj_in,
  output logic [HI_W-1:0] hi_q,
  output logic [LO_W-1:0] lo_q,
  output logic            adj_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      adj_q <= 1'b0;
    end else if (load_evt) begin
      hi_q  <= hi_in;
      lo_q  <= lo_in;
      adj_q <= adj_in;
    end
  end

  // R7
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(lo_q) && $stable(adj_q) && $stable(hi_q)));

endmodule

// File: rtl/cdiv_phase_counter.sv
module cdiv_phase_counter
  import cdiv_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] hi_ticks,
  input  logic [CNT_W-1:0] lo_ticks,
  output logic             phase_high,
  output logic             rise_stb,
  output logic             load_evt
);

  phase_e           state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero   = (cnt == '0);
  assign phase_high = (state == PH_HIGH);
  assign load_evt   = en && ((state == PH_IDLE) || ((state == PH_LOW) && cnt_zero));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      rise_stb <= 1'b0;
    end else if (!en) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      rise_stb <= 1'b0;
    end else begin
      unique case (state)
        PH_IDLE: begin
          state    <= PH_HIGH;
          cnt      <= hi_ticks - 1'b1;
          rise_stb <= 1'b1;
        end
        PH_HIGH: begin
          rise_stb <= 1'b0;
          if (cnt_zero) begin
            state <= PH_LOW;
            cnt   <= lo_ticks - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt_zero) begin
            state    <= PH_HIGH;
            cnt      <= hi_ticks - 1'b1;
            rise_stb <= 1'b1;
          end else begin
            cnt      <= cnt - 1'b1;
            rise_stb <= 1'b0;
          end
        end
        default: begin
          state    <= PH_IDLE;
          cnt      <= '0;
          rise_stb <= 1'b0;
        end
      endcase
    end
  end

  // R8
  stb_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (phase_high && !$past(phase_high)));

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!phase_high && !rise_stb));

  // R3
  high_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase_high && !cnt_zero) |=> phase_high);

  // R4
  low_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (state == PH_LOW) && !cnt_zero) |=> (state == PH_LOW));

endmodule

// File: rtl/conv_clk_prescaler.sv
module conv_clk_prescaler #(
  parameter int HI_W = 5,
  parameter int LO_W = 3
) (
  input  logic            clk2x,
  input  logic            rst_n,
  input  logic            en,
  input  logic [HI_W-1:0] hi_cnt,
  input  logic [LO_W-1:0] lo_cnt,
  input  logic            half_adj,
  output logic            div_clk,
  output logic            rise_stb
);

  localparam int MAX_HI_TICKS = 2 * (1 << HI_W) + 1;
  localparam int CNT_W        = $clog2(MAX_HI_TICKS + 1);

  logic            load_evt;
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic            adj_q;
  logic [CNT_W-1:0] hi_ticks_w;
  logic [CNT_W-1:0] lo_ticks_w;

  // A new high phase uses the live fields; the low phase uses the latched copy.
  assign hi_ticks_w = CNT_W'(cdiv_pkg::high_ticks(int'(hi_cnt), half_adj));
  assign lo_ticks_w = CNT_W'(cdiv_pkg::low_ticks(int'(lo_q), adj_q));

  cdiv_field_latch #(.HI_W(HI_W), .LO_W(LO_W)) u_latch (
    .clk      (clk2x),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .hi_in    (hi_cnt),
    .lo_in    (lo_cnt),
    .adj_in   (half_adj),
    .hi_q     (hi_q),
    .lo_q     (lo_q),
    .adj_q    (adj_q)
  );

  cdiv_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk2x),
    .rst_n      (rst_n),
    .en         (en),
    .hi_ticks   (hi_ticks_w),
    .lo_ticks   (lo_ticks_w),
    .phase_high (div_clk),
    .rise_stb   (rise_stb),
    .load_evt   (load_evt)
  );

  // R5
  always_comb begin
    lo_nonzero_chk: assert (lo_ticks_w != '0);
  end

  // R2
  start_high_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (en && !div_clk && load_evt) |=> (div_clk && rise_stb));

endmodule

// File: tb/tb_conv_clk_prescaler.sv
module tb_conv_clk_prescaler;

  logic       clk2x = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [4:0] hi_cnt = '0;
  logic [2:0] lo_cnt = '0;
  logic       half_adj = 1'b0;
  logic       div_clk;
  logic       rise_stb;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  int wd       = 0;

  always #4 clk2x = ~clk2x;

  conv_clk_prescaler dut (
    .clk2x(clk2x), .rst_n(rst_n), .en(en), .hi_cnt(hi_cnt),
    .lo_cnt(lo_cnt), .half_adj(half_adj), .div_clk(div_clk), .rise_stb(rise_stb)
  );

  // {hi, lo, adj, expected high ticks, expected low ticks}
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{3, 3, 0, 8, 8},
    '{3, 3, 1, 9, 7},
    '{0, 0, 0, 2, 2},
    '{0, 0, 1, 3, 1},
    '{31, 7, 0, 64, 16},
    '{31, 7, 1, 65, 15},
    '{10, 2, 1, 23, 5},
    '{5, 0, 0, 12, 2}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk2x) begin
    wd++;
    if (wd > 100000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      finish_run();
    end
  end

  // Counts samples while div_clk stays at lvl; the first sample is the current one.
  task automatic count_run(input bit lvl, input bit first_rise, output int n);
    int bad_stb = 0;
    n = 0;
    while (div_clk == lvl && n < 300) begin
      if (lvl && n == 0 && first_rise) begin
        if (!rise_stb) bad_stb++;
      end else if (rise_stb) begin
        bad_stb++;
      end
      n++;
      @(negedge clk2x);
    end
    check(bad_stb == 0, "R8", bad_stb, 0);
  endtask

  initial begin
    int h, l, h2, l2;
    string t_hi, t_lo;
    // R1: reset holds output low even with en high
    en = 1'b1; hi_cnt = 5'd2; lo_cnt = 3'd1;
    repeat (4) @(negedge clk2x);
    check(div_clk == 0 && rise_stb == 0, "R1", {div_clk, rise_stb}, 0);
    en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk2x);
    check(div_clk == 0, "R1", div_clk, 0);

    for (int v = 0; v < NV; v++) begin
      en = 1'b0;
      hi_cnt = 5'(VEC[v][0]); lo_cnt = 3'(VEC[v][1]); half_adj = VEC[v][2] != 0;
      @(negedge clk2x); @(negedge clk2x);
      check(div_clk == 0, "R1", div_clk, 0);
      en = 1'b1;
      @(negedge clk2x);
      check(div_clk == 1 && rise_stb == 1, "R2", {div_clk, rise_stb}, 3);
      t_hi = half_adj ? "R5" : "R3";
      t_lo = half_adj ? "R5" : "R4";
      count_run(1'b1, 1'b1, h);
      count_run(1'b0, 1'b0, l);
      check(h == VEC[v][3], t_hi, h, VEC[v][3]);
      check(l == VEC[v][4], t_lo, l, VEC[v][4]);
      check(h + l == 2 * (VEC[v][0] + VEC[v][1] + 2), "R6", h + l, 2 * (VEC[v][0] + VEC[v][1] + 2));
      count_run(1'b1, 1'b1, h2);
      check(h2 == VEC[v][3], t_hi, h2, VEC[v][3]);
    end

    // R7: mid-period field change only takes effect on the next high phase
    en = 1'b0; hi_cnt = 5'd3; lo_cnt = 3'd3; half_adj = 1'b0;
    @(negedge clk2x); @(negedge clk2x);
    en = 1'b1;
    @(negedge clk2x);
    @(negedge clk2x);
    hi_cnt = 5'd0; lo_cnt = 3'd0; half_adj = 1'b1;
    count_run(1'b1, 1'b0, h);
    check(h + 1 == 8, "R7", h + 1, 8);
    count_run(1'b0, 1'b0, l);
    check(l == 8, "R7", l, 8);
    count_run(1'b1, 1'b1, h2);
    check(h2 == 3, "R7", h2, 3);
    count_run(1'b0, 1'b0, l2);
    check(l2 == 1, "R7", l2, 1);

    // R9: drop en during a high phase, then re-enable
    en = 1'b0; hi_cnt = 5'd4; lo_cnt = 3'd2; half_adj = 1'b0;
    @(negedge clk2x);
    en = 1'b1;
    repeat (3) @(negedge clk2x);
    check(div_clk == 1, "R9", div_clk, 1);
    en = 1'b0;
    @(negedge clk2x);
    check(div_clk == 0 && rise_stb == 0, "R9", {div_clk, rise_stb}, 0);
    h = 0;
    repeat (5) begin
      @(negedge clk2x);
      if (div_clk) h++;
    end
    check(h == 0, "R9", h, 0);
    en = 1'b1;
    @(negedge clk2x);
    check(div_clk == 1 && rise_stb == 1, "R9", {div_clk, rise_stb}, 3);
    count_run(1'b1, 1'b1, h);
    check(h == 10, "R9", h, 10);

    // R1: async reset during a run
    @(negedge clk2x);
    rst_n = 1'b0;
    #1;
    check(div_clk == 0 && rise_stb == 0, "R1", {div_clk, rise_stb}, 0);
    @(negedge clk2x);
    finish_run();
  end

endmodule